// File: doc/BRIEF.md
# Segment-table address translator

This block turns a virtual address into a physical address through a small table of segment descriptors held in registers. The top four bits of a 32-bit virtual address pick a segment. The low 28 bits are the offset within that segment. Each descriptor carries a 32-bit base, a 32-bit bound, a valid flag, and separate read and write permission flags. A controller loads or changes descriptors through a one-entry-per-cycle write port.

Each accepted lookup produces a registered response one cycle later. The response is either the physical address or a two-bit fault cause. A kernel uses these faults in two ways. It grows a segment on demand by raising the bound after a bound fault and retrying. It implements copy-on-write by clearing the write flag of a shared segment and reacting to the resulting protection fault. Several descriptors may carry the same base, so one physical region can be shared.

Top module: `seg_xlate`

## Requirements
- R1: After reset all eight descriptors are invalid, `rsp_valid` is low, and `req_ready` is high whenever reset is released.
- R2: The segment number is `req_vaddr[31:28]` and the offset is `req_vaddr[27:0]`. A lookup that passes every check returns `rsp_fault` = 2'b00 and `rsp_paddr` = base + zero-extended offset, modulo 2^32.
- R3: A segment number of 8 or more, or one whose descriptor has the valid flag clear, returns `rsp_fault` = 2'b01 (invalid segment).
- R4: An offset greater than or equal to the descriptor's bound returns `rsp_fault` = 2'b10 (bound violation). An offset of bound-1 translates normally.
- R5: A write (`req_write`=1) to a descriptor without the write flag, or a read to one without the read flag, returns `rsp_fault` = 2'b11 (permission violation).
- R6: When several faults apply, invalid segment wins over bound violation, and bound violation wins over permission violation.
- R7: A response (`rsp_valid` high for one cycle) follows exactly one cycle after each cycle with `req_valid` and `req_ready` both high, and at no other time.
- R8: A descriptor write in the same cycle as a lookup is not seen by that lookup. It is seen by the next lookup.
- R9: Two descriptors holding the same base return the same physical address for the same offset.
- R10: After a bound fault, raising that descriptor's bound makes a retry of the same address translate normally.
- R11: Any faulting response drives `rsp_paddr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Descriptor write strobe |
| tbl_sel | input | 3 | Descriptor index to write |
| tbl_base | input | 32 | Base to store |
| tbl_bound | input | 32 | Bound to store |
| tbl_vld | input | 1 | Valid flag to store |
| tbl_rd_ok | input | 1 | Read permission to store |
| tbl_wr_ok | input | 1 | Write permission to store |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block accepts a lookup |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 2 | 00 ok, 01 invalid, 10 bound, 11 permission |

## Verification
A descriptor update and a lookup of that same descriptor can fall in the same cycle. The bench provokes this by driving the write port and a request together. One case tightens a bound under a live lookup. The other validates a previously empty segment under a live lookup. The behavioural model applies table writes only after it has computed that cycle's expected response. So the same-cycle lookup must reflect the old descriptor, and the next lookup of the same address must reflect the new one. Both are compared on the following clock.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_COUNT = 8,
  parameter int SEG_W     = 4,
  parameter int OFF_W     = 28,
  parameter int AW        = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tbl_we,
  input  logic [$clog2(SEG_COUNT)-1:0] tbl_sel,
  input  logic [AW-1:0]                tbl_base,
  input  logic [AW-1:0]                tbl_bound,
  input  logic                         tbl_vld,
  input  logic                         tbl_rd_ok,
  input  logic                         tbl_wr_ok,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [SEG_W+OFF_W-1:0]       req_vaddr,
  input  logic                         req_write,
  output logic                         rsp_valid,
  output logic [AW-1:0]                rsp_paddr,
  output logic [1:0]                   rsp_fault
);
  localparam int IDX_W = $clog2(SEG_COUNT);
  localparam int EXT_W = AW - OFF_W;
  localparam logic [1:0] F_NONE  = 2'b00;
  localparam logic [1:0] F_INVAL = 2'b01;
  localparam logic [1:0] F_BOUND = 2'b10;
  localparam logic [1:0] F_PERM  = 2'b11;

  logic [AW-1:0] base_q  [SEG_COUNT];
  logic [AW-1:0] bound_q [SEG_COUNT];
  logic [SEG_COUNT-1:0] vld_q, rd_q, wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      for (int i = 0; i < SEG_COUNT; i++) begin
        base_q[i]  <= '0;
        bound_q[i] <= '0;
      end
    end else if (tbl_we) begin
      base_q[tbl_sel]  <= tbl_base;
      bound_q[tbl_sel] <= tbl_bound;
      vld_q[tbl_sel]   <= tbl_vld;
      rd_q[tbl_sel]    <= tbl_rd_ok;
      wr_q[tbl_sel]    <= tbl_wr_ok;
    end
  end

  logic [SEG_W-1:0] seg;
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    off;
  logic             in_range, hit, over, deny, accept;
  logic [1:0]       fault_d;

  assign seg      = req_vaddr[SEG_W+OFF_W-1:OFF_W];
  assign idx      = seg[IDX_W-1:0];
  assign off      = {{EXT_W{1'b0}}, req_vaddr[OFF_W-1:0]};
  assign in_range = 32'(seg) < SEG_COUNT;
  assign hit      = in_range && vld_q[idx];
  assign over     = off >= bound_q[idx];
  assign deny     = req_write ? !wr_q[idx] : !rd_q[idx];
  assign fault_d  = !hit ? F_INVAL : over ? F_BOUND : deny ? F_PERM : F_NONE;
  assign req_ready = rst_n;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= F_NONE;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_fault <= fault_d;
        rsp_paddr <= (fault_d == F_NONE) ? base_q[idx] + off : '0;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_COUNT = 8,
  parameter int SEG_W     = 4,
  parameter int OFF_W     = 28,
  parameter int AW        = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [SEG_W+OFF_W-1:0] req_vaddr,
  input logic                   rsp_valid,
  input logic [AW-1:0]          rsp_paddr,
  input logic [1:0]             rsp_fault
);
  always @(posedge clk)
    if (!rst_n) a_r1_ready_tracks_reset: assert (!req_ready);

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  a_r3_high_segment: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && 32'(req_vaddr[SEG_W+OFF_W-1:OFF_W]) >= SEG_COUNT)
      |=> rsp_fault == 2'b01);

  a_r11_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> rsp_paddr == '0);
endmodule

bind seg_xlate seg_xlate_chk #(.SEG_COUNT(SEG_COUNT), .SEG_W(SEG_W), .OFF_W(OFF_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault));

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_sel = '0;
  logic [31:0] tbl_base = '0, tbl_bound = '0;
  logic        tbl_vld = 1'b0, tbl_rd_ok = 1'b0, tbl_wr_ok = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int errors = 0, checks = 0;
  string tag = "R7";

  seg_xlate uut (.*);

  always #10 clk = ~clk;

  logic [31:0] m_base [8];
  logic [31:0] m_bound[8];
  bit          m_v[8], m_r[8], m_w[8];
  bit          exp_v;
  logic [31:0] exp_pa;
  logic [1:0]  exp_f;
  string       exp_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_r[i] = 0; m_w[i] = 0; m_base[i] = 0; m_bound[i] = 0; end
      exp_v = 0;
    end else begin
      exp_v = req_valid;
      exp_tag = tag;
      if (req_valid) begin
        int s;
        logic [31:0] o;
        s = int'(req_vaddr[31:28]);
        o = {4'h0, req_vaddr[27:0]};
        exp_pa = 0;
        if (s >= 8 || !m_v[s]) exp_f = 2'b01;
        else if (o >= m_bound[s]) exp_f = 2'b10;
        else if (req_write ? !m_w[s] : !m_r[s]) exp_f = 2'b11;
        else begin exp_f = 2'b00; exp_pa = m_base[s] + o; end
      end
      if (tbl_we) begin
        m_base[tbl_sel] = tbl_base; m_bound[tbl_sel] = tbl_bound;
        m_v[tbl_sel] = tbl_vld; m_r[tbl_sel] = tbl_rd_ok; m_w[tbl_sel] = tbl_wr_ok;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && (exp_v || rsp_valid)) begin
      checks++;
      if (rsp_valid !== exp_v || (exp_v && (rsp_fault !== exp_f || rsp_paddr !== exp_pa))) begin
        errors++;
        $display("FAIL %s: valid=%0b fault=%b paddr=%h expected valid=%0b fault=%b paddr=%h",
                 exp_tag, rsp_valid, rsp_fault, rsp_paddr, exp_v, exp_f, exp_pa);
      end
    end
  end

  task automatic set_ent(input int idx, input logic [31:0] b, input logic [31:0] bd,
                         input bit v, input bit r, input bit w);
    tbl_we = 1; tbl_sel = 3'(idx); tbl_base = b; tbl_bound = bd;
    tbl_vld = v; tbl_rd_ok = r; tbl_wr_ok = w;
  endtask

  task automatic put_ent(input int idx, input logic [31:0] b, input logic [31:0] bd,
                         input bit v, input bit r, input bit w);
    set_ent(idx, b, bd, v, r, w);
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic lookup(input logic [31:0] va, input bit wr, input string t);
    tag = t; req_valid = 1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic lookup_with_write(input logic [31:0] va, input bit wr, input string t,
                                   input int idx, input logic [31:0] b, input logic [31:0] bd,
                                   input bit v, input bit r, input bit w);
    set_ent(idx, b, bd, v, r, w);
    tag = t; req_valid = 1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 0; tbl_we = 0;
  endtask

  task automatic direct(input bit ok, input string t, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, expv);
    end
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    direct(req_ready == 1'b0, "R1 ready in reset", int'(req_ready), 0);
    direct(rsp_valid == 1'b0, "R1 rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    direct(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    direct(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    lookup(32'h0000_0000, 0, "R1 empty table");
    lookup(32'h6000_0004, 1, "R1 empty table");

    put_ent(0, 32'h1000_0000, 32'h100, 1, 1, 1);
    put_ent(1, 32'h1000_0000, 32'h40, 1, 1, 0);
    put_ent(2, 32'h8000_0000, 32'h20, 1, 0, 1);
    put_ent(7, 32'hFFFF_FFF0, 32'h1000_0000, 1, 1, 1);

    lookup(32'h0000_0010, 0, "R2 basic");
    lookup(32'h7000_0020, 1, "R2 wraparound");
    lookup(32'h7FFF_FFFF, 0, "R2 max offset");
    lookup(32'h1000_0010, 0, "R9 shared base");
    lookup(32'h0000_00FF, 0, "R4 bound-1");
    lookup(32'h0000_0100, 0, "R4 at bound");
    lookup(32'h0FFF_FFFF, 1, "R4 far over");
    lookup(32'h1000_0000, 1, "R5 write read-only");
    lookup(32'h2000_0000, 0, "R5 read write-only");
    lookup(32'h2000_0001, 1, "R5 write allowed");
    lookup(32'h8000_0000, 0, "R3 segment 8");
    lookup(32'hF000_0000, 1, "R3 segment 15");
    lookup(32'h5000_0000, 0, "R3 unloaded");
    lookup(32'h1000_0050, 1, "R6 bound over perm");
    put_ent(2, 32'h8000_0000, 32'h20, 0, 0, 1);
    lookup(32'h2000_0000, 0, "R6 invalid over perm");
    lookup(32'h2000_0100, 0, "R6 invalid over bound");

    lookup(32'h0000_0200, 0, "R10 before grow");
    put_ent(0, 32'h1000_0000, 32'h400, 1, 1, 1);
    lookup(32'h0000_0200, 0, "R10 retry after grow");

    lookup_with_write(32'h0000_0300, 0, "R8 old bound", 0, 32'h1000_0000, 32'h300, 1, 1, 1);
    lookup(32'h0000_0300, 0, "R8 new bound");
    lookup_with_write(32'h5000_0008, 1, "R8 old invalid", 5, 32'h4000_0000, 32'h80, 1, 1, 1);
    lookup(32'h5000_0008, 1, "R8 new valid");

    tag = "R7 back-to-back";
    req_valid = 1; req_write = 0; req_vaddr = 32'h0000_0001;
    @(negedge clk); req_vaddr = 32'h1000_0002;
    @(negedge clk); req_vaddr = 32'h5000_0003;
    @(negedge clk); req_valid = 0;
    repeat (3) @(negedge clk);
    direct(rsp_valid == 1'b0, "R7 idle", int'(rsp_valid), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule